// File: doc/BRIEF.md
# Downlink Burst Reassembly and PDU Extractor

This block sits after the forward-error-correction decoder in a downlink receive path. Decoded FEC blocks reach it one byte at a time. Each byte carries the number of the burst it belongs to. Blocks of different bursts come interleaved, but every burst is made only of whole blocks. The block keeps one small parse context per burst and selects the context named by the incoming burst number. A protocol data unit that is split across several FEC blocks therefore carries on correctly when that burst's next block arrives, even if blocks of other bursts came in between.

Each data unit starts with a six-byte generic MAC header. An 11-bit length field in that header gives the size of the whole unit, header included. The block forwards every byte of each unit, header included, on an output byte stream. Each output byte is tagged with its burst number and with start and end markers, and goes to the CRC checking stage that follows. The block also handles three irregular cases. It drops the padding at the tail of a burst. It cuts a unit short when the header length is impossible. It closes a unit that the end of its burst truncates. For the last two it raises an abort marker together with the end marker. Flow control is plain valid/ready on both sides. The block accepts no input while the downstream stage refuses output.

Top module: `dl_pdu_extract`

## Requirements
- R1: While reset is applied and in the cycle after it, out_valid is 0. Reset also returns every burst context to the start of a header, so a unit left half-parsed before reset has no effect on later parsing.
- R2: A byte is parsed in the context chosen by in_burst. A unit whose bytes are spread over several FEC blocks, with blocks of other bursts in between, is forwarded complete and in order, and each byte carries its own burst number on out_burst.
- R3: The header is 6 bytes. Header bytes are numbered 0 to 5. The length is {byte2[2:0], byte3}. It counts the whole unit, header included. Bits 7..3 of byte 2 have no effect. For a length of 6 or more, out_eop is 1 exactly on the unit's last byte.
- R4: Every byte of a unit is forwarded, header included. out_sop is 1 on header byte 0 only. Forwarded bytes leave in the order they were accepted, one cycle after acceptance when out_ready is 1.
- R5: If header byte 0 of a new unit is 0xFF, that byte and every later byte of the same burst, up to and including its end-of-burst byte, are dropped and never appear at the output.
- R6: If the length is below 6, header byte 3 is forwarded with out_eop=1 and out_abort=1. The rest of that burst is dropped. The contexts of the other bursts are not affected.
- R7: A byte with in_burst_last=1 and in_blk_last=1 ends its burst. After it, the next byte of that burst is parsed as header byte 0. in_burst_last without in_blk_last does not end a burst.
- R8: If the end-of-burst byte falls inside a unit before its length is reached, that byte is forwarded with out_eop=1 and out_abort=1. When a unit's natural end falls on the end-of-burst byte, out_abort stays 0.
- R9: in_ready is 0 in every cycle in which out_ready is 0. While out_valid=1 and out_ready=0, all output fields hold. No byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Decoded FEC block byte |
| in_burst | input | BID_W (2) | Burst number of the byte |
| in_blk_last | input | 1 | Last byte of an FEC block |
| in_burst_last | input | 1 | Last byte of the burst (counted only together with in_blk_last) |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Unit byte |
| out_burst | output | BID_W (2) | Burst number of the unit |
| out_sop | output | 1 | First byte of a unit |
| out_eop | output | 1 | Last byte of a unit |
| out_abort | output | 1 | Unit is cut short (header error or truncated burst); only with out_eop |

## Verification
Two functions can act on the same byte: the end of a burst and the end of a unit. The end of a unit can come from the length counter expiring or from a header error. The sweep bursts are built so that each burst's final unit ends exactly on the end-of-burst byte, which must give a clean end marker with no abort. Other bursts end in the middle of a unit, on header byte 3 of a long unit, on a one-byte header stub, or right after a bad length field. In each of those cases the expected abort and end markers are worked out from the byte position alone. The same traffic is also run under random output stalls, so that stall cycles line up with these shared-byte events.

// File: rtl/dl_pdu_pkg.sv
// Package: shared constants and types of the downlink PDU extractor.
// Header byte positions are fixed because the parser decodes them.
package dl_pdu_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 11;
    localparam int IDX_W  = 3;

    // Header byte positions that the parser decodes.
    localparam logic [IDX_W-1:0] IDX_LEN_HI   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_LEN_LO   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_HDR_LAST = 3'd5;

    // Smallest legal unit length (the header alone).
    localparam logic [LEN_W-1:0] MIN_PDU_LEN  = 11'd6;
    // Bytes already seen when the length field completes.
    localparam logic [LEN_W-1:0] SEEN_AT_LEN  = 11'd4;

    localparam logic [BYTE_W-1:0] PAD_MARK    = 8'hFF;

    typedef enum logic [1:0] {
        PS_HDR  = 2'd0,
        PS_PAY  = 2'd1,
        PS_PAD  = 2'd2,
        PS_DROP = 2'd3
    } parse_t;

    typedef struct packed {
        parse_t            state;
        logic [IDX_W-1:0]  idx;     // header byte index
        logic [LEN_W-1:0]  remain;  // bytes still to come after the current one
        logic [2:0]        len_hi;  // captured upper length bits
    } ctx_t;

    localparam ctx_t CTX_IDLE = '{state: PS_HDR, idx: '0, remain: '0, len_hi: '0};

endpackage

// File: rtl/dl_parse_step.sv
// Module: dl_parse_step
// Combinational parse step of one byte against one burst context.
// It returns the updated context and the output tags of the byte.
// Assumes: the caller writes nxt back only when the byte is accepted.
module dl_parse_step
    import dl_pdu_pkg::*;
(
    input  ctx_t              cur,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              burst_end,
    output ctx_t              nxt,
    output logic              emit,
    output logic              sop,
    output logic              eop,
    output logic              abort
);

    logic [LEN_W-1:0] len_full;

    // Purpose: full length value formed when the low length byte is seen.
    assign len_full = {cur.len_hi, byte_in};

    // Purpose: header/payload/pad state machine for a single byte.
    always_comb begin
        nxt   = cur;
        emit  = 1'b0;
        sop   = 1'b0;
        eop   = 1'b0;
        abort = 1'b0;
        unique case (cur.state)
            PS_HDR: begin
                if (cur.idx == '0) begin
                    if (byte_in == PAD_MARK) begin
                        nxt.state = PS_PAD;
                    end else begin
                        emit    = 1'b1;
                        sop     = 1'b1;
                        nxt.idx = cur.idx + 3'd1;
                    end
                end else if (cur.idx == IDX_LEN_LO) begin
                    emit = 1'b1;
                    if (len_full < MIN_PDU_LEN) begin
                        eop       = 1'b1;
                        abort     = 1'b1;
                        nxt.state = PS_DROP;
                    end else begin
                        nxt.remain = len_full - SEEN_AT_LEN;
                        nxt.idx    = cur.idx + 3'd1;
                    end
                end else if (cur.idx < IDX_LEN_LO) begin
                    emit = 1'b1;
                    if (cur.idx == IDX_LEN_HI) begin
                        nxt.len_hi = byte_in[2:0];
                    end
                    nxt.idx = cur.idx + 3'd1;
                end else begin
                    emit = 1'b1;
                    if (cur.remain == 11'd1) begin
                        eop = 1'b1;
                        nxt = CTX_IDLE;
                    end else begin
                        nxt.remain = cur.remain - 11'd1;
                        if (cur.idx == IDX_HDR_LAST) begin
                            nxt.state = PS_PAY;
                            nxt.idx   = '0;
                        end else begin
                            nxt.idx = cur.idx + 3'd1;
                        end
                    end
                end
            end
            PS_PAY: begin
                emit = 1'b1;
                if (cur.remain == 11'd1) begin
                    eop = 1'b1;
                    nxt = CTX_IDLE;
                end else begin
                    nxt.remain = cur.remain - 11'd1;
                end
            end
            default: begin
                // Padding or error tail: consume silently.
            end
        endcase
        if (burst_end) begin
            if (emit && !eop) begin
                eop   = 1'b1;
                abort = 1'b1;
            end
            nxt = CTX_IDLE;
        end
    end

endmodule

// File: rtl/dl_ctx_bank.sv
// Module: dl_ctx_bank
// Register bank that holds one parse context per burst, with one read
// port and one write port, both indexed by burst number.
// Assumes: NUM_BURSTS is a power of two, so every index is in range.
module dl_ctx_bank
    import dl_pdu_pkg::*;
#(
    parameter int NUM_BURSTS = 4,
    localparam int BID_W = $clog2(NUM_BURSTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BID_W-1:0] rd_sel,
    output ctx_t             rd_ctx,
    input  logic             wr_en,
    input  logic [BID_W-1:0] wr_sel,
    input  ctx_t             wr_ctx
);

    ctx_t ctx_q [NUM_BURSTS];

    for (genvar g = 0; g < NUM_BURSTS; g++) begin : g_ctx
        // Purpose: hold and update the context of burst g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctx_q[g] <= CTX_IDLE;
            end else if (wr_en && (wr_sel == BID_W'(g))) begin
                ctx_q[g] <= wr_ctx;
            end
        end
    end

    // Purpose: present the context of the selected burst.
    assign rd_ctx = ctx_q[rd_sel];

endmodule

// File: rtl/dl_out_reg.sv
// Module: dl_out_reg
// Output register stage. It advances only when the downstream stage is
// ready, so a byte it shows holds until that byte is taken.
// Assumes: the caller loads it only in cycles where adv is high.
module dl_out_reg
    import dl_pdu_pkg::*;
#(
    parameter int BID_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              ld_valid,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic [BID_W-1:0]  ld_burst,
    input  logic              ld_sop,
    input  logic              ld_eop,
    input  logic              ld_abort,
    output logic              q_valid,
    output logic [BYTE_W-1:0] q_data,
    output logic [BID_W-1:0]  q_burst,
    output logic              q_sop,
    output logic              q_eop,
    output logic              q_abort
);

    // Purpose: capture the next output byte or hold under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_burst <= '0;
            q_sop   <= 1'b0;
            q_eop   <= 1'b0;
            q_abort <= 1'b0;
        end else if (adv) begin
            q_valid <= ld_valid;
            q_data  <= ld_data;
            q_burst <= ld_burst;
            q_sop   <= ld_sop;
            q_eop   <= ld_eop;
            q_abort <= ld_abort;
        end
    end

endmodule

// File: rtl/dl_pdu_extract.sv
// Module: dl_pdu_extract (top)
// Sorts interleaved decoded FEC block bytes to per-burst parse contexts
// and emits the contained units as a framed byte stream for CRC checking.
// Assumes: each burst ends on a byte carrying both block-last and
// burst-last; NUM_BURSTS is a power of two and at least 2.
module dl_pdu_extract
    import dl_pdu_pkg::*;
#(
    parameter int NUM_BURSTS = 4,
    localparam int BID_W = $clog2(NUM_BURSTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [BID_W-1:0]  in_burst,
    input  logic              in_blk_last,
    input  logic              in_burst_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic [BID_W-1:0]  out_burst,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_abort
);

    ctx_t cur_ctx;
    ctx_t nxt_ctx;
    logic fire;
    logic burst_end;
    logic st_emit;
    logic st_sop;
    logic st_eop;
    logic st_abort;

    // Purpose: accept input only while the output side can move.
    assign in_ready  = out_ready;
    assign fire      = in_valid && in_ready;
    // Purpose: a burst ends only on a byte that also closes its FEC block.
    assign burst_end = in_burst_last && in_blk_last;

    dl_ctx_bank #(
        .NUM_BURSTS (NUM_BURSTS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_sel (in_burst),
        .rd_ctx (cur_ctx),
        .wr_en  (fire),
        .wr_sel (in_burst),
        .wr_ctx (nxt_ctx)
    );

    dl_parse_step u_step (
        .cur       (cur_ctx),
        .byte_in   (in_data),
        .burst_end (burst_end),
        .nxt       (nxt_ctx),
        .emit      (st_emit),
        .sop       (st_sop),
        .eop       (st_eop),
        .abort     (st_abort)
    );

    dl_out_reg #(
        .BID_W (BID_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (out_ready),
        .ld_valid (fire && st_emit),
        .ld_data  (in_data),
        .ld_burst (in_burst),
        .ld_sop   (st_sop),
        .ld_eop   (st_eop),
        .ld_abort (st_abort),
        .q_valid  (out_valid),
        .q_data   (out_data),
        .q_burst  (out_burst),
        .q_sop    (out_sop),
        .q_eop    (out_eop),
        .q_abort  (out_abort)
    );

endmodule

// File: rtl/dl_pdu_extract_chk.sv
// Module: dl_pdu_extract_chk
// Protocol checker on the output stream. It rebuilds the unit framing
// of each burst from the output bytes alone and checks markers and lengths.
// Assumes: it is bound to dl_pdu_extract with matching NUM_BURSTS.
module dl_pdu_extract_chk #(
    parameter int NUM_BURSTS = 4,
    localparam int BID_W = $clog2(NUM_BURSTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic [BID_W-1:0] out_burst,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_abort
);

    logic        take;
    logic        open_q [NUM_BURSTS];
    logic [10:0] cnt_q  [NUM_BURSTS];
    logic [2:0]  hi_q   [NUM_BURSTS];
    logic [10:0] len_q  [NUM_BURSTS];

    assign take = out_valid && out_ready;

    // Purpose: track per-burst framing as observed on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BURSTS; i++) begin
                open_q[i] <= 1'b0;
                cnt_q[i]  <= '0;
                hi_q[i]   <= '0;
                len_q[i]  <= '0;
            end
        end else if (take) begin
            open_q[out_burst] <= !out_eop;
            cnt_q[out_burst]  <= out_eop ? 11'd0 : cnt_q[out_burst] + 11'd1;
            if (cnt_q[out_burst] == 11'd2) hi_q[out_burst] <= out_data[2:0];
            if (cnt_q[out_burst] == 11'd3) len_q[out_burst] <= {hi_q[out_burst], out_data};
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
        $stable(out_burst) && $stable(out_sop) && $stable(out_eop) && $stable(out_abort)));

    assert_sop_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_sop) |-> !open_q[out_burst]);

    assert_cont_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !out_sop) |-> open_q[out_burst]);

    assert_len_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_eop && !out_abort) |->
        ((cnt_q[out_burst] >= 11'd5) && ((cnt_q[out_burst] + 11'd1) == len_q[out_burst])));

    assert_bad_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cnt_q[out_burst] == 11'd3) && ({hi_q[out_burst], out_data} < 11'd6))
        |-> (out_eop && out_abort));

    assert_abort_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_abort) |-> out_eop);

endmodule

bind dl_pdu_extract dl_pdu_extract_chk #(.NUM_BURSTS(NUM_BURSTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_burst (out_burst),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_abort (out_abort)
);

// File: tb/tb_dl_pdu_extract.sv
// Bench: builds burst contents from unit descriptions, splits them into
// interleaved FEC blocks and predicts every output byte and marker.
module tb_dl_pdu_extract;

    localparam int NB = 4;
    localparam int BMAX = 1024;
    localparam int FMAX = 4096;
    localparam int MAXCYC = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [1:0] in_burst = '0;
    logic       in_blk_last = 1'b0;
    logic       in_burst_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic [1:0] out_burst;
    logic       out_sop;
    logic       out_eop;
    logic       out_abort;

    always #5 clk = ~clk;

    dl_pdu_extract #(.NUM_BURSTS(NB)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_burst(in_burst), .in_blk_last(in_blk_last), .in_burst_last(in_burst_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_burst(out_burst), .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort)
    );

    typedef struct {
        logic [7:0] d;
        logic [1:0] b;
        logic       s;
        logic       e;
        logic       a;
        int         r;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] bdat [NB][BMAX];
    bit         bem  [NB][BMAX];
    bit         bsop [NB][BMAX];
    bit         beop [NB][BMAX];
    bit         babt [NB][BMAX];
    int         breq [NB][BMAX];
    int         blen [NB];
    logic [7:0] fdat [FMAX];
    logic [1:0] fbid [FMAX];
    bit         fblk [FMAX];
    bit         fbl  [FMAX];
    int         nf;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    int         pdu_seq = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic string rname(int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic put(int b, logic [7:0] d, bit em, bit s, bit e, bit a, int r);
        bdat[b][blen[b]] = d;
        bem[b][blen[b]]  = em;
        bsop[b][blen[b]] = s;
        beop[b][blen[b]] = e;
        babt[b][blen[b]] = a;
        breq[b][blen[b]] = r;
        blen[b]++;
    endtask

    // One unit with declared length len, of which nbytes are written.
    // A cut unit (nbytes < len) or a bad length must be last in its burst.
    task automatic add_pdu(int b, int len, int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            bit em, s, e, a;
            int r;
            case (i)
                0: d = 8'(8'h10 + b);
                1: d = 8'(pdu_seq);
                2: d = {5'(len * 3 + b + 1), 3'(len >> 8)};
                3: d = 8'(len);
                default: d = 8'(i * 13 + len + b * 29);
            endcase
            s = (i == 0);
            if (len < 6) begin
                em = (i <= 3);
                e  = (i == 3);
                a  = (i == 3);
            end else begin
                em = 1'b1;
                a  = (i == nbytes - 1) && (nbytes < len);
                e  = (i == len - 1) || a;
            end
            if (i == 0 && blen[b] == 0) r = 7;
            else if (i == 0) r = 4;
            else if (len < 6 && i == 3) r = 6;
            else if (a) r = 8;
            else if (e) r = 3;
            else r = 2;
            put(b, d, em, s, e, a, r);
        end
        pdu_seq++;
    endtask

    task automatic add_pad(int b, int n);
        put(b, 8'hFF, 0, 0, 0, 0, 5);
        for (int i = 1; i < n; i++) put(b, 8'(i * 7 + 3), 0, 0, 0, 0, 5);
    endtask

    // Split each burst into blocks of blk bytes and interleave round-robin.
    task automatic flatten(int blk);
        int pos [NB];
        bit more;
        nf = 0;
        for (int b = 0; b < NB; b++) pos[b] = 0;
        more = 1'b1;
        while (more) begin
            more = 1'b0;
            for (int b = 0; b < NB; b++) begin
                for (int k = 0; k < blk && pos[b] < blen[b]; k++) begin
                    fdat[nf] = bdat[b][pos[b]];
                    fbid[nf] = 2'(b);
                    fbl[nf]  = (pos[b] == blen[b] - 1);
                    fblk[nf] = (k == blk - 1) || fbl[nf];
                    if (bem[b][pos[b]]) begin
                        expq.push_back('{d: bdat[b][pos[b]], b: 2'(b), s: bsop[b][pos[b]],
                                         e: beop[b][pos[b]], a: babt[b][pos[b]], r: breq[b][pos[b]]});
                    end
                    pos[b]++;
                    nf++;
                end
                if (pos[b] < blen[b]) more = 1'b1;
            end
        end
        for (int b = 0; b < NB; b++) blen[b] = 0;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive the flattened stream; duty/16 is the output-ready probability.
    task automatic run(int duty);
        int idx = 0;
        int idle = 0;
        int extra = 0;
        while (idle < 8 && cyc < MAXCYC) begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (int'(lfsr[3:0]) < duty);
            in_valid  = (idx < nf) && (lfsr[7:5] != 3'd0);
            in_data       = in_valid ? fdat[idx] : 8'h00;
            in_burst      = in_valid ? fbid[idx] : 2'd0;
            in_blk_last   = in_valid ? fblk[idx] : 1'b0;
            in_burst_last = in_valid ? fbl[idx]  : 1'b0;
            #1;
            if (!out_ready) check(in_ready == 1'b0, "R9", "in_ready during stall", in_ready, 0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    extra++;
                    check(1'b0, "R5", "unexpected output byte", out_data, 0);
                end else begin
                    exp_t x;
                    x = expq.pop_front();
                    check(out_data == x.d && out_burst == x.b && out_sop == x.s &&
                          out_eop == x.e && out_abort == x.a, rname(x.r),
                          "data,burst,sop,eop,abort",
                          {out_data, 2'b0, out_burst, 1'b0, out_sop, out_eop, out_abort},
                          {x.d, 2'b0, x.b, 1'b0, x.s, x.e, x.a});
                end
            end
            if (in_valid && in_ready) idx++;
            if (idx >= nf && expq.size() == 0) idle++;
        end
        in_valid = 1'b0;
        check(expq.size() == 0, "R9", "bytes never delivered", expq.size(), 0);
        check(extra == 0, "R5", "dropped bytes leaked", extra, 0);
        expq.delete();
    endtask

    task automatic specials(bit variant);
        // Burst 0: long unit using upper length bits, then minimum unit.
        add_pdu(0, 300, 300);
        add_pdu(0, 6, 6);
        if (variant) add_pdu(0, 100, 4);
        // Burst 1: unit then padding, or padding only.
        if (!variant) add_pdu(1, 9, 9);
        add_pad(1, variant ? 5 : 11);
        // Burst 2: bad length tail.
        add_pdu(2, 7, 7);
        add_pdu(2, variant ? 0 : 5, 12);
        // Burst 3: truncated unit, or one-byte stub.
        if (!variant) begin
            add_pdu(3, 20, 20);
            add_pdu(3, 40, 15);
        end else begin
            add_pdu(3, 30, 1);
        end
    endtask

    initial begin
        #(20 * MAXCYC * 1ns);
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) blen[b] = 0;
        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        out_ready = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        // Leave burst 0 half-parsed, then reset again.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_burst = 2'd0;
            in_data  = (i == 3) ? 8'd40 : 8'(i + 1);
            in_blk_last = 1'b0;
            in_burst_last = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after second reset", out_valid, 0);

        // Length sweep over several block sizes and stall densities.
        for (int s = 0; s < 4; s++) begin
            int blk;
            int duty;
            blk  = (s == 0) ? 1 : (s == 1) ? 3 : (s == 2) ? 8 : 17;
            duty = (s == 0) ? 16 : (s == 1) ? 11 : (s == 2) ? 16 : 6;
            for (int b = 0; b < NB; b++)
                for (int len = 6 + b + s; len < 60; len += 5) add_pdu(b, len, len);
            flatten(blk);
            run(duty);
        end

        specials(1'b0);
        flatten(4);
        run(10);

        specials(1'b1);
        flatten(7);
        run(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule